// File: doc/BRIEF.md
# Dual-Endian CSR Target Decoder

This block sits behind a bus target and turns simple word requests into accesses on a small bank of 32-bit control and status registers. A request carries a valid strobe, a write flag, a space select (memory or I/O), a window-relative byte address, four byte enables and write data. The block answers every request with a one-cycle ready pulse on the following clock edge. Reads also return data with a read-valid strobe on that edge.

The 1 KB memory window shows the register bank twice. The lower half is a little-endian view. The upper half, chosen by address bit 9, is a big-endian view in which byte lanes 0 and 3 and lanes 1 and 2 are exchanged on both write data and read data. A separate 256-byte I/O window shows the same registers once, in little-endian order.

Only whole-word accesses change state. A read returns the full word whatever byte enables it carries. A write without all four enables completes normally but leaves the register untouched. The memory window never reads ahead, so a read touches only the word it addresses.

Top module: `csr_endian_decoder`

## Requirements
- R1: Synchronous active-low reset clears rsp_ready, rsp_rvalid and rsp_rdata to 0 and sets every register to 0.
- R2: A request sampled with req_valid=1 gives rsp_ready=1 on the next clock edge for exactly one cycle, writes included. rsp_ready is 0 after any cycle without a request.
- R3: A read request gives rsp_rvalid=1 together with its rsp_ready. A write request gives rsp_rvalid=0.
- R4: A memory access with req_io=0, req_addr[9]=0 and req_addr[8]=0 reaches word index req_addr[7:2] in little-endian order: write data is stored unchanged and read data is returned unchanged.
- R5: A memory access with req_io=0, req_addr[9]=1 and req_addr[8]=0 reaches the same word index with the bytes reversed, so that returned or stored bits [7:0] pair with register bits [31:24] and bits [15:8] pair with bits [23:16], on both reads and writes.
- R6: An access with req_io=1 and req_addr[9:8]=0 reaches word index req_addr[7:2] in little-endian order, the same physical register as the memory views. An I/O access with req_addr[9:8]≠0 reads 0 and its writes are ignored.
- R7: A write whose req_be is not 4'b1111 leaves the register unchanged and still completes with rsp_ready.
- R8: A read returns the complete 32-bit word for any req_be value, including 4'b0000.
- R9: Indices at or above NUM_REGS (48 by default) and memory addresses with req_addr[8]=1 are unimplemented: they read 0, writes to them change no register, and they still complete.
- R10: req_addr[1:0] has no effect on which register is accessed.
- R11: rsp_rdata is 0 in every cycle where rsp_rvalid is 0, and 0 for reads of unimplemented locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O window, 0 = memory window |
| req_addr | input | ADDR_W (10) | Byte address within the selected window |
| req_be | input | DATA_W/8 (4) | Byte enables, bit n covers bits [8n+7:8n] |
| req_wdata | input | DATA_W (32) | Write data as seen on the bus |
| rsp_ready | output | 1 | Completion pulse one cycle after a request |
| rsp_rvalid | output | 1 | Read data valid, with rsp_ready of a read |
| rsp_rdata | output | DATA_W (32) | Read data, 0 when not valid |

## Verification
Every register is reached through three views, so a corrupted word, a wrong swap or a wrong index decode shows up as a mismatched value on the very next read through any view. The lag is exactly one cycle after that read request. A wrongly accepted partial or out-of-window write stays hidden until the affected word is read again. For that reason the bench follows each such write with a read of the word it could have changed and of the neighbour it could have aliased into. Handshake faults, such as a missing or extra ready or read-valid, appear on the cycle right after the request.

// File: rtl/csr_dec_pkg.sv
// Shared types for the dual-endian CSR target decoder.
// Assumes: a single request per cycle and no outstanding transactions.
package csr_dec_pkg;

    // Which view of the register bank a request targets.
    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_MEM_LE = 2'd1,
        WIN_MEM_BE = 2'd2,
        WIN_IO     = 2'd3
    } csr_win_e;

    // Result of address classification for one request.
    typedef struct packed {
        csr_win_e win;   // selected view
        logic     hit;   // location is backed by a register
        logic     full;  // all byte lanes enabled
    } csr_decode_t;

endpackage

// File: rtl/csr_addr_decode.sv
// Classifies a request into a window view, a word index and read/write
// enables. Partial writes and unimplemented locations never produce a
// write enable. Assumes ADDR_W-2 >= IDX_W+2, so at least one gap bit
// exists between the word index and the alias-select bit.
module csr_addr_decode
    import csr_dec_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int IDX_W    = 6,
    parameter int NUM_REGS = 48,
    parameter int LANES    = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    output logic [IDX_W-1:0]  word_idx,
    output logic              swap_en,
    output logic              wr_en,
    output logic              rd_en
);

    localparam int SPAN_LO   = IDX_W + 2;   // first bit above the word index
    localparam int ALIAS_BIT = ADDR_W - 1;  // big-endian view select
    localparam logic [IDX_W:0] REG_LIMIT = (IDX_W+1)'(NUM_REGS);

    csr_decode_t dec;
    logic        mem_gap_clear;
    logic        io_high_clear;
    logic        slot_present;

    // Address field extraction and implemented-slot check.
    always_comb begin
        mem_gap_clear = (req_addr[ALIAS_BIT-1:SPAN_LO] == '0);
        io_high_clear = (req_addr[ADDR_W-1:SPAN_LO] == '0);
        word_idx      = req_addr[SPAN_LO-1:2];
        slot_present  = ({1'b0, word_idx} < REG_LIMIT);
    end

    // Window and view classification.
    always_comb begin
        if (req_io) begin
            dec.win = io_high_clear ? WIN_IO : WIN_NONE;
        end else if (!mem_gap_clear) begin
            dec.win = WIN_NONE;
        end else if (req_addr[ALIAS_BIT]) begin
            dec.win = WIN_MEM_BE;
        end else begin
            dec.win = WIN_MEM_LE;
        end
        dec.hit  = (dec.win != WIN_NONE) && slot_present;
        dec.full = &req_be;
    end

    // Access enables towards the register bank and lane swapper.
    always_comb begin
        swap_en = (dec.win == WIN_MEM_BE);
        wr_en   = req_valid &  req_write & dec.hit & dec.full;
        rd_en   = req_valid & ~req_write & dec.hit;
    end

endmodule

// File: rtl/csr_lane_swap.sv
// Optional byte-lane reversal: lane g of the output takes lane
// LANES-1-g of the input when swap_en is set, else passes through.
// Purely combinational; used on both the write and the read path.
module csr_lane_swap #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      swap_en,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout
);

    logic [LANES*LANE_W-1:0] reversed;

    // One mirrored lane per generate iteration.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign reversed[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
    end

    // Select the swapped or the straight word.
    always_comb begin
        dout = swap_en ? reversed : din;
    end

endmodule

// File: rtl/csr_reg_bank.sv
// Register file of NUM_REGS words with one write and one read port.
// Read is combinational, write takes effect at the clock edge.
// Assumes the caller never enables a write to an index >= NUM_REGS;
// reads of such an index return zero.
module csr_reg_bank #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 48,
    parameter int IDX_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [IDX_W:0] REG_LIMIT = (IDX_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] words [NUM_REGS];

    // Storage update: clear on reset, else write the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    // Read port with zero for indices beyond the bank.
    always_comb begin
        rd_data = '0;
        if ({1'b0, rd_idx} < REG_LIMIT) begin
            rd_data = words[rd_idx];
        end
    end

endmodule

// File: rtl/csr_endian_decoder.sv
// Dual-endian CSR target decoder top. Decodes one request per cycle,
// swaps write data for the big-endian view, stores into the register
// bank, and registers a one-cycle completion with read data.
// Assumes: window-relative addresses (base matching is done upstream),
// DATA_W a multiple of 8, ADDR_W >= 10.
module csr_endian_decoder
    import csr_dec_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_io,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_ready,
    output logic                  rsp_rvalid,
    output logic [DATA_W-1:0]     rsp_rdata
);

    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0]  word_idx;
    logic              swap_en;
    logic              bank_we;
    logic              rd_en;
    logic [DATA_W-1:0] store_word;
    logic [DATA_W-1:0] bank_word;
    logic [DATA_W-1:0] bus_word;

    csr_addr_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS),
        .LANES    (LANES)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .word_idx  (word_idx),
        .swap_en   (swap_en),
        .wr_en     (bank_we),
        .rd_en     (rd_en)
    );

    csr_lane_swap #(
        .LANES  (LANES),
        .LANE_W (8)
    ) u_wr_swap (
        .swap_en (swap_en),
        .din     (req_wdata),
        .dout    (store_word)
    );

    csr_reg_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .wr_idx  (word_idx),
        .wr_data (store_word),
        .rd_idx  (word_idx),
        .rd_data (bank_word)
    );

    csr_lane_swap #(
        .LANES  (LANES),
        .LANE_W (8)
    ) u_rd_swap (
        .swap_en (swap_en),
        .din     (bank_word),
        .dout    (bus_word)
    );

    // Response stage: one-cycle ready, read-valid and gated read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ready  <= 1'b0;
            rsp_rvalid <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_ready  <= req_valid;
            rsp_rvalid <= req_valid & ~req_write;
            rsp_rdata  <= rd_en ? bus_word : '0;
        end
    end

endmodule

// File: rtl/csr_endian_decoder_chk.sv
// Protocol checker for csr_endian_decoder, attached by bind below.
// Observes the request/response ports and the bank write enable.
module csr_endian_decoder_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic                req_io,
    input logic                gap_bit,
    input logic [DATA_W/8-1:0] req_be,
    input logic                rsp_ready,
    input logic                rsp_rvalid,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                bank_we
);

    assert_ready_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    assert_no_spurious_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);

    assert_rvalid_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rsp_rvalid && rsp_ready));

    assert_no_rvalid_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_rvalid);

    assert_partial_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !(&req_be)) |-> !bank_we);

    assert_gap_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_io && gap_bit) |=> (rsp_rdata == '0));

    assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_rvalid |-> (rsp_rdata == '0));

endmodule

bind csr_endian_decoder csr_endian_decoder_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_io     (req_io),
    .gap_bit    (req_addr[ADDR_W-2]),
    .req_be     (req_be),
    .rsp_ready  (rsp_ready),
    .rsp_rvalid (rsp_rvalid),
    .rsp_rdata  (rsp_rdata),
    .bank_we    (bank_we)
);

// File: tb/test_csr_endian_decoder.sv
// Scoreboard bench: driver tasks push expected responses into a queue,
// a monitor pops and compares them one cycle after each request.
module test_csr_endian_decoder;

    localparam int NREG = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ready;
    logic        rsp_rvalid;
    logic [31:0] rsp_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    csr_endian_decoder i_csr_endian_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_io     (req_io),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .rsp_ready  (rsp_ready),
        .rsp_rvalid (rsp_rvalid),
        .rsp_rdata  (rsp_rdata)
    );

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] pat(input int i);
        return {8'(i), 8'(i + 8'h40), 8'(i + 8'h80), 8'(i + 8'hC0)};
    endfunction

    function automatic logic [9:0] a_of(input bit be_view, input int i);
        return {be_view, 1'b0, 6'(i), 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input bit io, input logic [9:0] a, input logic [3:0] be,
                      input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_io = io;
        req_addr = a; req_be = be; req_wdata = 32'hBAD0BAD0;
        it.is_read = 1'b1; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input bit io, input logic [9:0] a, input logic [3:0] be,
                      input logic [31:0] d, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_io = io;
        req_addr = a; req_be = be; req_wdata = d;
        it.is_read = 1'b0; it.exp = 32'h0; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    // Monitor: one response per queued request, nothing otherwise (R2, R3, R11).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (sb_q.size() > 0) begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(rsp_ready == 1'b1, {it.tag, " R2 ready"}, 32'(rsp_ready), 32'h1);
                    check(rsp_rvalid == it.is_read, {it.tag, " R3 rvalid"},
                          32'(rsp_rvalid), 32'(it.is_read));
                    check(rsp_rdata == it.exp, {it.tag, " R11 rdata"}, rsp_rdata, it.exp);
                end else if (rsp_ready || rsp_rvalid) begin
                    check(1'b0, "R2 spurious response", {30'h0, rsp_ready, rsp_rvalid}, 32'h0);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet out of reset
        check(rsp_ready == 1'b0 && rsp_rvalid == 1'b0 && rsp_rdata == 32'h0,
              "R1 reset outputs", rsp_rdata, 32'h0);
        rd(1'b0, 10'h014, 4'hF, 32'h0, "R1 reg5 after reset");
        rd(1'b1, 10'h0BC, 4'hF, 32'h0, "R1 reg47 after reset");
        idle(2);

        // R4: little-endian memory view
        wr(1'b0, 10'h014, 4'hF, 32'h11223344, "R4 write");
        rd(1'b0, 10'h014, 4'hF, 32'h11223344, "R4 read");
        // R5: big-endian view of same word, and a write through it
        rd(1'b0, 10'h214, 4'hF, 32'h44332211, "R5 read swapped");
        wr(1'b0, 10'h218, 4'hF, 32'hAABBCCDD, "R5 write swapped");
        rd(1'b0, 10'h018, 4'hF, 32'hDDCCBBAA, "R5 LE view of BE write");
        rd(1'b0, 10'h218, 4'hF, 32'hAABBCCDD, "R5 BE readback");
        idle(1);

        // R6: I/O window shares the registers
        rd(1'b1, 10'h018, 4'hF, 32'hDDCCBBAA, "R6 io read");
        wr(1'b1, 10'h01C, 4'hF, 32'h0A0B0C0D, "R6 io write");
        rd(1'b0, 10'h01C, 4'hF, 32'h0A0B0C0D, "R6 mem LE of io write");
        rd(1'b0, 10'h21C, 4'hF, 32'h0D0C0B0A, "R6 mem BE of io write");
        rd(1'b1, 10'h11C, 4'hF, 32'h0, "R6 io outside window");
        wr(1'b1, 10'h11C, 4'hF, 32'hFFFFFFFF, "R6 io outside write");
        rd(1'b1, 10'h01C, 4'hF, 32'h0A0B0C0D, "R6 io outside write ignored");
        idle(1);

        // R7: partial writes dropped in every view
        wr(1'b0, 10'h014, 4'h3, 32'hDEADBEEF, "R7 partial LE");
        rd(1'b0, 10'h014, 4'hF, 32'h11223344, "R7 after partial LE");
        wr(1'b0, 10'h214, 4'h7, 32'hDEADBEEF, "R7 partial BE");
        rd(1'b0, 10'h014, 4'hF, 32'h11223344, "R7 after partial BE");
        wr(1'b1, 10'h014, 4'h0, 32'hDEADBEEF, "R7 partial io");
        rd(1'b1, 10'h014, 4'hF, 32'h11223344, "R7 after partial io");

        // R8: partial reads return the whole word
        rd(1'b0, 10'h014, 4'h1, 32'h11223344, "R8 be=1");
        rd(1'b0, 10'h214, 4'h8, 32'h44332211, "R8 be=8 BE view");
        rd(1'b1, 10'h014, 4'h0, 32'h11223344, "R8 be=0 io");
        idle(2);

        // R9: unimplemented locations
        wr(1'b0, 10'h114, 4'hF, 32'h12345678, "R9 gap write");
        rd(1'b0, 10'h114, 4'hF, 32'h0, "R9 gap read");
        rd(1'b0, 10'h014, 4'hF, 32'h11223344, "R9 gap did not alias");
        rd(1'b0, 10'h314, 4'hF, 32'h0, "R9 gap BE read");
        wr(1'b0, a_of(1'b0, 50), 4'hF, 32'h55555555, "R9 idx50 write");
        rd(1'b0, a_of(1'b0, 50), 4'hF, 32'h0, "R9 idx50 read");
        rd(1'b1, a_of(1'b0, 63), 4'hF, 32'h0, "R9 idx63 io read");
        rd(1'b0, a_of(1'b0, 47), 4'hF, 32'h0, "R9 idx47 untouched");

        // R10: low address bits ignored
        rd(1'b0, 10'h017, 4'hF, 32'h11223344, "R10 addr[1:0]=3 read");
        wr(1'b0, 10'h01A, 4'hF, 32'h01020304, "R10 addr[1:0]=2 write");
        rd(1'b0, 10'h018, 4'hF, 32'h01020304, "R10 readback");
        rd(1'b0, 10'h219, 4'hF, 32'h04030201, "R10 BE readback");
        idle(1);

        // R4/R5/R6: back-to-back fill and readback of the whole bank
        for (int i = 0; i < NREG; i++) begin
            wr(1'b0, a_of(i[0], i), 4'hF, pat(i), "R4 R5 fill");
        end
        for (int i = 0; i < NREG; i++) begin
            rd(1'b1, a_of(1'b0, i), 4'hF, i[0] ? swp(pat(i)) : pat(i), "R6 io sweep");
        end
        for (int i = 0; i < NREG; i++) begin
            rd(1'b0, a_of(1'b1, i), 4'hF, i[0] ? pat(i) : swp(pat(i)), "R5 BE sweep");
        end
        idle(3);
        wait (sb_q.size() == 0);
        idle(2);

        // R1: reset mid-run clears the bank
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd(1'b0, 10'h014, 4'hF, 32'h0, "R1 reg5 after second reset");
        rd(1'b0, a_of(1'b1, 47), 4'hF, 32'h0, "R1 reg47 after second reset");
        idle(3);
        wait (sb_q.size() == 0);
        idle(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule